// File: doc/BRIEF.md
# Descriptor-Chained Transmit DMA Engine

This engine feeds the transmit FIFO of a card-write path with data taken from host memory. Software builds a chain of four-word descriptors, each naming a buffer. Writing the first descriptor's address into the engine starts the transfer. The engine reads the descriptor and checks that hardware owns it. It then waits for the command stage to finish cleanly, and after that copies the buffer into the FIFO whenever the FIFO side asks for data.

Data is read in four-word bursts while at least four words remain. Shorter remainders are read one word at a time. When a buffer is finished, the engine writes the descriptor's first word back with the ownership flag cleared. It then either follows the chain or reports completion. If it finds a descriptor that software still owns, it parks until software issues a poll demand.

Top module: `txdma_engine`

## Requirements
- R1: A write to register index 0 (list base) while the engine is idle starts a fetch of four single-word reads at the base address, base+4, base+8 and base+12. Memory request, address, direction and burst flag hold steady until the request is acknowledged.
- R2: If bit 31 of the first descriptor word is 0, the engine issues no further memory traffic and no FIFO writes. It sets status bit 1 (descriptor unavailable).
- R3: A write of any value to register index 3 (poll demand) while suspended refetches the same descriptor. The same write has no effect in any other state.
- R4: No buffer data is read until cmd_done is 1 and cmd_err is 0 together.
- R5: The buffer length in bytes is taken from word 1 bits [12:0], and its word address from word 2. ceil(bytes/4) words are moved, and each memory beat writes one FIFO word. A transfer starts only while dma_req is 1. It is a 4-beat burst when at least 4 words remain, otherwise a single beat.
- R6: When bit 2 of word 0 (last flag) is 0, the next descriptor is read at the address in word 3. If bits [1:0] of that address are not 0, the engine sets status bit 2 (chain address error) and goes idle. Every memory address the engine issues has bits [1:0] equal to 0.
- R7: After each buffer, word 0 is written back to the descriptor address with bit 31 cleared and its other bits unchanged, as a single-beat write.
- R8: Finishing a descriptor whose last flag is 1 sets status bit 0 (transmit done).
- R9: Status (register index 2) clears the bits written as 1. irq is the OR of the status bits that are enabled in register index 1 (bits [2:0]).
- R10: After reset, status, enable and irq are 0 and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 base, 1 enable, 2 status, 3 poll |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at reg_addr |
| cmd_done | input | 1 | Command stage finished |
| cmd_err | input | 1 | Command stage reported an error |
| dma_req | input | 1 | FIFO watermark request for data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_burst | output | 1 | Read is a 4-beat burst |
| mem_addr | output | 32 | Byte address of the current beat |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write data |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks buffer lengths of 0, 1, 4, 6 and 10 words. A design that miscounts the tail would push one word too many or too few, or would burst past the end of the buffer. It parks the engine on a software-owned descriptor and checks that the engine stays silent until a poll demand, and that a poll demand outside suspend starts nothing. A faulty design would spin on memory or start on its own. It holds back command completion, asserts the command error and drops the FIFO request, each of which must stall data movement. It also runs a two-descriptor chain and a misaligned chain pointer: a broken design would lose the second buffer, skip a write-back, or follow the bad pointer instead of reporting it.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
    // Controller states
    typedef enum logic [3:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_SUSP, ST_WCMD,
        ST_XWAIT, ST_READ, ST_WBACK, ST_NEXT
    } txdma_state_e;

    // Register indices
    localparam logic [1:0] RIDX_BASE = 2'd0;
    localparam logic [1:0] RIDX_IEN  = 2'd1;
    localparam logic [1:0] RIDX_STAT = 2'd2;
    localparam logic [1:0] RIDX_POLL = 2'd3;

    // Status bit positions
    localparam int STAT_W     = 3;
    localparam int SB_TXDONE  = 0;
    localparam int SB_UNAVAIL = 1;
    localparam int SB_ADERR   = 2;

    // Descriptor word 0 flags
    localparam int OWN_POS  = 31;
    localparam int LAST_POS = 2;
endpackage

// File: rtl/txdma_regs.sv
// Register file: list base, interrupt enable, write-1-to-clear status,
// and poll demand. Assumes set pulses from the controller take priority
// over a clear arriving in the same cycle.
module txdma_regs
    import txdma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [STAT_W-1:0] stat_set,
    output logic [DW-1:0]     base_addr,
    output logic              start_pulse,
    output logic              poll_pulse,
    output logic              irq
);
    logic [DW-1:0]     base_q;
    logic [STAT_W-1:0] ien_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] clr_mask;

    // Decode write-1-to-clear mask for the status register
    always_comb begin
        clr_mask = '0;
        if (reg_wr && reg_addr == RIDX_STAT)
            clr_mask = reg_wdata[STAT_W-1:0];
    end

    // Hold base, enable and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ien_q  <= '0;
            stat_q <= '0;
        end else begin
            if (reg_wr && reg_addr == RIDX_BASE) base_q <= reg_wdata;
            if (reg_wr && reg_addr == RIDX_IEN)  ien_q  <= reg_wdata[STAT_W-1:0];
            stat_q <= (stat_q & ~clr_mask) | stat_set;
        end
    end

    // Read mux for software
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RIDX_BASE: reg_rdata = base_q;
            RIDX_IEN:  reg_rdata[STAT_W-1:0] = ien_q;
            RIDX_STAT: reg_rdata[STAT_W-1:0] = stat_q;
            default:   reg_rdata = '0;
        endcase
    end

    // Command strobes and interrupt combine
    assign start_pulse = reg_wr && reg_addr == RIDX_BASE;
    assign poll_pulse  = reg_wr && reg_addr == RIDX_POLL;
    assign base_addr   = reg_wdata;
    assign irq         = |(stat_q & ien_q);
endmodule

// File: rtl/txdma_ctrl.sv
// Descriptor walker and data mover. Assumes word-aligned buffers and
// a memory port that acknowledges each beat with valid read data.
module txdma_ctrl
    import txdma_pkg::*;
#(
    parameter int DW    = 32,
    parameter int SZW   = 13,
    parameter int BURST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pulse,
    input  logic              poll_pulse,
    input  logic [DW-1:0]     base_addr,
    input  logic              cmd_done,
    input  logic              cmd_err,
    input  logic              dma_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_burst,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              fifo_wr,
    output logic [DW-1:0]     fifo_wdata,
    output logic [STAT_W-1:0] stat_set
);
    localparam int WCW = SZW;
    localparam int BCW = (BURST > 1) ? $clog2(BURST) : 1;

    txdma_state_e   state_q;
    logic [DW-1:0]  desc_addr_q;
    logic [1:0]     wsel_q;
    logic [DW-1:0]  des0_q;
    logic [SZW-1:0] size_q;
    logic [DW-1:0]  nxt_q;
    logic [DW-1:0]  ptr_q;
    logic [WCW-1:0] rem_q;
    logic [BCW-1:0] beat_q;
    logic           burst_q;
    logic [SZW:0]   size_rnd;
    logic [WCW-1:0] words;
    logic           own_ok;
    logic           is_last;
    logic           nxt_bad;

    // Round byte count up to whole words
    assign size_rnd = {1'b0, size_q} + (SZW+1)'(3);
    assign words    = WCW'(size_rnd[SZW:2]);
    assign own_ok   = des0_q[OWN_POS];
    assign is_last  = des0_q[LAST_POS];
    assign nxt_bad  = |nxt_q[1:0];

    // Sequence descriptor fetch, data bursts and write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            desc_addr_q <= '0;
            wsel_q      <= '0;
            des0_q      <= '0;
            size_q      <= '0;
            nxt_q       <= '0;
            ptr_q       <= '0;
            rem_q       <= '0;
            beat_q      <= '0;
            burst_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_pulse) begin
                    desc_addr_q <= base_addr;
                    wsel_q      <= '0;
                    state_q     <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    case (wsel_q)
                        2'd0: des0_q <= mem_rdata;
                        2'd1: size_q <= mem_rdata[SZW-1:0];
                        2'd2: ptr_q  <= mem_rdata;
                        default: nxt_q <= mem_rdata;
                    endcase
                    wsel_q <= wsel_q + 2'd1;
                    if (wsel_q == 2'd3) state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    rem_q   <= words;
                    state_q <= own_ok ? ST_WCMD : ST_SUSP;
                end
                ST_SUSP: if (poll_pulse) begin
                    wsel_q  <= '0;
                    state_q <= ST_FETCH;
                end
                ST_WCMD: if (cmd_done && !cmd_err) state_q <= ST_XWAIT;
                ST_XWAIT: begin
                    if (rem_q == '0) begin
                        state_q <= ST_WBACK;
                    end else if (dma_req) begin
                        burst_q <= rem_q >= WCW'(BURST);
                        beat_q  <= '0;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: if (mem_ack) begin
                    ptr_q  <= ptr_q + DW'(4);
                    rem_q  <= rem_q - WCW'(1);
                    beat_q <= beat_q + BCW'(1);
                    if (!burst_q || beat_q == BCW'(BURST-1)) state_q <= ST_XWAIT;
                end
                ST_WBACK: if (mem_ack) state_q <= ST_NEXT;
                ST_NEXT: begin
                    if (is_last || nxt_bad) begin
                        state_q <= ST_IDLE;
                    end else begin
                        desc_addr_q <= nxt_q;
                        wsel_q      <= '0;
                        state_q     <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port from the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_burst = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr_q + {{(DW-4){1'b0}}, wsel_q, 2'b00};
            end
            ST_READ: begin
                mem_req   = 1'b1;
                mem_burst = burst_q;
                mem_addr  = ptr_q;
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr_q;
                mem_wdata = des0_q;
                mem_wdata[OWN_POS] = 1'b0;
            end
            default: ;
        endcase
    end

    // Produce FIFO writes and status set pulses
    always_comb begin
        fifo_wr    = (state_q == ST_READ) && mem_ack;
        fifo_wdata = mem_rdata;
        stat_set   = '0;
        stat_set[SB_UNAVAIL] = (state_q == ST_CHECK) && !own_ok;
        stat_set[SB_TXDONE]  = (state_q == ST_NEXT) && is_last;
        stat_set[SB_ADERR]   = (state_q == ST_NEXT) && !is_last && nxt_bad;
    end
endmodule

// File: rtl/txdma_engine.sv
// Top of the transmit DMA engine: joins the register file and the
// descriptor controller. Assumes one clock domain and synchronous reset.
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int DW    = 32,
    parameter int SZW   = 13,
    parameter int BURST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          cmd_done,
    input  logic          cmd_err,
    input  logic          dma_req,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_burst,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_wdata,
    output logic          irq
);
    logic [STAT_W-1:0] stat_set;
    logic [DW-1:0]     base_addr;
    logic              start_pulse;
    logic              poll_pulse;

    txdma_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_set(stat_set),
        .base_addr(base_addr), .start_pulse(start_pulse),
        .poll_pulse(poll_pulse), .irq(irq)
    );

    txdma_ctrl #(.DW(DW), .SZW(SZW), .BURST(BURST)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
        .poll_pulse(poll_pulse), .base_addr(base_addr),
        .cmd_done(cmd_done), .cmd_err(cmd_err), .dma_req(dma_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .stat_set(stat_set)
    );
endmodule

// File: rtl/txdma_chk.sv
// Protocol checker for the engine's memory and FIFO ports.
// Assumes it is bound to txdma_engine.
module txdma_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_burst,
    input logic          mem_ack,
    input logic [DW-1:0] mem_addr,
    input logic          own_bit,
    input logic          fifo_wr
);
    AST_ALIGNED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R6
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) && !$past(mem_ack) |-> $stable(mem_addr) && $stable(mem_we) && $stable(mem_burst)); // R1
    AST_WB_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !own_bit); // R7
    AST_NO_BURST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_burst); // R7
    AST_FIFO_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> mem_ack && mem_req && !mem_we); // R5
endmodule

bind txdma_engine txdma_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_burst(mem_burst), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .own_bit(mem_wdata[31]), .fifo_wr(fifo_wr)
);

// File: tb/sim_txdma_engine.sv
`timescale 1ns/100ps
module sim_txdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_done = 1'b1;
    logic        cmd_err = 1'b0;
    logic        dma_req = 1'b1;
    logic        mem_req, mem_we, mem_burst;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        fifo_wr;
    logic [31:0] fifo_wdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [0:255];

    // Statistics gathered at the ports
    logic clr = 1'b0;
    int fifo_cnt, bb_cnt, wb_cnt, dr_cnt;
    logic [31:0] first_w, last_w;

    always #2.5 clk = ~clk;

    txdma_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_done(cmd_done),
        .cmd_err(cmd_err), .dma_req(dma_req), .mem_req(mem_req),
        .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .irq(irq)
    );

    // Memory model: acknowledges one cycle after each request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            end
        end
    end

    always @(posedge clk) begin
        if (clr) begin
            fifo_cnt <= 0; bb_cnt <= 0; wb_cnt <= 0; dr_cnt <= 0;
            first_w <= '0; last_w <= '0;
        end else begin
            if (mem_req && mem_ack && mem_we) wb_cnt <= wb_cnt + 1;
            if (mem_req && mem_ack && !mem_we && mem_addr < 32'h100) dr_cnt <= dr_cnt + 1;
            if (mem_ack && mem_burst) bb_cnt <= bb_cnt + 1;
            if (fifo_wr) begin
                if (fifo_cnt == 0) first_w <= fifo_wdata;
                last_w   <= fifo_wdata;
                fifo_cnt <= fifo_cnt + 1;
            end
        end
    end

    typedef struct packed {
        logic [12:0] size;
        logic [11:0] words;
        logic [11:0] bbeats;
    } vec_t;
    localparam vec_t VECS [0:4] = '{
        '{13'd4,  12'd1,  12'd0},
        '{13'd16, 12'd4,  12'd4},
        '{13'd22, 12'd6,  12'd4},
        '{13'd37, 12'd10, 12'd8},
        '{13'd0,  12'd0,  12'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_stat(input int b, input int maxc);
        logic [31:0] s;
        for (int i = 0; i < maxc; i++) begin
            reg_read(2'd2, s);
            if (s[b]) break;
        end
    endtask

    task automatic put_desc(input int w, input bit own, input bit last, input logic [12:0] sz,
                            input logic [31:0] bufa, input logic [31:0] nxt);
        mem[w]   = {own, 28'd0, last, 2'b00};
        mem[w+1] = {19'd0, sz};
        mem[w+2] = bufa;
        mem[w+3] = nxt;
    endtask

    task automatic clear_all();
        reg_write(2'd2, 32'h7);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s;
        for (int i = 0; i < 256; i++) mem[i] = 32'hD000_0000 | i;
        clr = 1'b1;
        idle(4);
        rst_n = 1'b1; clr = 1'b0;

        // R10: reset state
        reg_read(2'd2, s); chk(s == 0, "R10 status after reset", s, 0);
        reg_read(2'd1, s); chk(s == 0, "R10 enable after reset", s, 0);
        chk(irq == 1'b0, "R10 irq after reset", {31'd0, irq}, 0);
        chk(mem_req == 1'b0, "R10 no request after reset", {31'd0, mem_req}, 0);

        // Table walk: single descriptor of varying length
        for (int v = 0; v < 5; v++) begin
            put_desc(0, 1'b1, 1'b1, VECS[v].size, 32'h100, 32'h0);
            clear_all();
            reg_write(2'd0, 32'h0);
            wait_stat(0, 400);
            idle(2);
            reg_read(2'd2, s);
            chk(s[0] == 1'b1, "R8 transmit done set", s, 1);
            chk(dr_cnt == 4, "R1 four descriptor reads", dr_cnt, 4);
            chk(fifo_cnt == int'(VECS[v].words), "R5 FIFO word count", fifo_cnt, VECS[v].words);
            chk(bb_cnt == int'(VECS[v].bbeats), "R5 burst beat count", bb_cnt, VECS[v].bbeats);
            chk(wb_cnt == 1, "R7 one write-back", wb_cnt, 1);
            chk(mem[0] == 32'h0000_0004, "R7 own cleared, last kept", mem[0], 32'h4);
            if (VECS[v].words != 0) begin
                chk(first_w == (32'hD000_0000 | 64), "R5 first data word", first_w, 32'hD000_0040);
                chk(last_w == (32'hD000_0000 | (64 + int'(VECS[v].words) - 1)), "R5 last data word",
                    last_w, 32'hD000_0000 | (64 + int'(VECS[v].words) - 1));
            end
        end

        // R9: masking, irq, write-1-to-clear
        chk(irq == 1'b0, "R9 irq masked while disabled", {31'd0, irq}, 0);
        reg_write(2'd1, 32'h1);
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq when enabled", {31'd0, irq}, 1);
        reg_write(2'd2, 32'h1);
        reg_read(2'd2, s);
        chk(s == 0, "R9 status cleared by W1C", s, 0);
        chk(irq == 1'b0, "R9 irq drops after clear", {31'd0, irq}, 0);
        reg_write(2'd1, 32'h0);

        // R2/R3: suspend on software-owned descriptor, resume on poll
        put_desc(0, 1'b0, 1'b1, 13'd8, 32'h100, 32'h0);
        clear_all();
        reg_write(2'd0, 32'h0);
        wait_stat(1, 100);
        idle(20);
        reg_read(2'd2, s);
        chk(s == 32'h2, "R2 unavailable flag only", s, 32'h2);
        chk(dr_cnt == 4 && fifo_cnt == 0 && wb_cnt == 0, "R2 no traffic while suspended", dr_cnt, 4);
        mem[0] = 32'h8000_0004;
        reg_write(2'd3, 32'hDEAD_BEEF);
        wait_stat(0, 200);
        idle(2);
        chk(dr_cnt == 8, "R3 refetch after poll", dr_cnt, 8);
        chk(fifo_cnt == 2, "R3 transfer after poll", fifo_cnt, 2);

        // R3: poll in idle has no effect
        clear_all();
        reg_write(2'd3, 32'h0);
        idle(15);
        chk(dr_cnt == 0 && fifo_cnt == 0, "R3 poll ignored when idle", dr_cnt, 0);

        // R4: command gating
        put_desc(0, 1'b1, 1'b1, 13'd8, 32'h100, 32'h0);
        clear_all();
        cmd_done = 1'b0;
        reg_write(2'd0, 32'h0);
        idle(30);
        chk(fifo_cnt == 0, "R4 no data before cmd_done", fifo_cnt, 0);
        cmd_done = 1'b1; cmd_err = 1'b1;
        idle(30);
        chk(fifo_cnt == 0, "R4 no data with cmd_err", fifo_cnt, 0);
        cmd_err = 1'b0;
        wait_stat(0, 200);
        idle(2);
        chk(fifo_cnt == 2, "R4 data after clean completion", fifo_cnt, 2);

        // R5: no transfer without FIFO request
        put_desc(0, 1'b1, 1'b1, 13'd8, 32'h100, 32'h0);
        clear_all();
        dma_req = 1'b0;
        reg_write(2'd0, 32'h0);
        idle(30);
        chk(fifo_cnt == 0, "R5 idle without dma_req", fifo_cnt, 0);
        dma_req = 1'b1;
        wait_stat(0, 200);
        idle(2);
        chk(fifo_cnt == 2, "R5 moves once requested", fifo_cnt, 2);

        // R6: two-descriptor chain
        put_desc(0, 1'b1, 1'b0, 13'd8, 32'h100, 32'h40);
        put_desc(16, 1'b1, 1'b1, 13'd12, 32'h200, 32'h0);
        clear_all();
        reg_write(2'd0, 32'h0);
        wait_stat(0, 400);
        idle(2);
        chk(fifo_cnt == 5, "R6 chain word count", fifo_cnt, 5);
        chk(wb_cnt == 2, "R7 write-back per descriptor", wb_cnt, 2);
        chk(mem[0] == 32'h0 && mem[16] == 32'h4, "R7 both handed back", mem[0], 0);
        chk(last_w == (32'hD000_0000 | 130), "R6 second buffer data", last_w, 32'hD000_0082);

        // R6: misaligned chain pointer
        put_desc(0, 1'b1, 1'b0, 13'd8, 32'h100, 32'h42);
        clear_all();
        reg_write(2'd0, 32'h0);
        wait_stat(2, 200);
        idle(10);
        reg_read(2'd2, s);
        chk(s == 32'h4, "R6 address error only", s, 32'h4);
        chk(dr_cnt == 4 && fifo_cnt == 2, "R6 stops at bad pointer", dr_cnt, 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule